// File: doc/BRIEF.md
# PCI Configuration Access Router

This block sits behind a host-side configuration window and turns each configuration data access into the right target action. The host first loads a 32-bit configuration address register. That register holds the address byte-swapped, so the register offset lands in its top byte. Each later data access of 1, 2 or 4 bytes then goes to one of two places. Device 0 with function 0 goes to the bridge's own 256-byte configuration header. Any other device number goes to a downstream device port on bus 0, but only if that device number has been registered.

Inside the bridge, the local header stores values most-significant byte first. It comes out of reset with fixed identification and control defaults. Registration is a single-cycle request carrying a device number, and the answer comes back in the same cycle: accepted or rejected. Accesses that cannot be served are dropped. These are accesses to a nonzero bus, accesses with an unsupported size, and accesses to an absent device. A dropped read returns zero, and a one-cycle error flag follows.

Top module: `pcicfg_router`

## Requirements
- R1: A pulse on `addr_wr` loads `addr_wdata` into the configuration address register, which reads back on `addr_q` and clears to zero on reset. The fields are decoded from it as follows:
  - register offset: bits 31:24, with bits 25:24 treated as zero
  - device: bits 23:19
  - function: bits 18:16
  - bus: bits 15:8
- R2: An access whose bus field is nonzero reads as 0, changes no header byte and raises no port select.
- R3: An access with device 0 and function 0 targets the local header and raises no port select, even if device number 0 is registered. Device 0 with another function is routed like any other device.
- R4: An access to a registered device number k below NUM_DEV raises only `dev_sel[k]`, together with `dev_rd[k]` for a read or `dev_wr[k]` for a write. The access presents the aligned offset on `dev_off`, the write data on `dev_wdata` and the size on `dev_size`, and a read returns port k's data in the same cycle.
- R5: An access to an unregistered device number, or to one not below NUM_DEV, reads as 0 and raises no port select.
- R6: Local reads are big-endian and right-aligned in `acc_rdata`, with `acc_size` coded as 1, 2 or 4:
  - size 1 returns the byte at the offset
  - size 2 returns the bytes at offset and offset+1, with the offset byte in bits 15:8
  - size 4 returns the bytes at offset through offset+3, with the offset byte in bits 31:24
- R7: Local writes store bytes in the same big-endian order. Size 1 writes `acc_wdata[7:0]`, size 2 writes `acc_wdata[15:0]`, and size 4 writes the whole word. Each write takes effect at the next clock edge.
- R8: An access of any other size reads as 0, changes no header byte and raises no port select.
- R9: After reset the local header holds these values, with every other byte zero:
  - byte 0x06 = 0x80
  - byte 0x08 = 0x40
  - byte 0x0B = 0x06
  - byte 0x73 = 0xCD
  - bytes 0xA8 to 0xAB = 10 00 00 FF
  - bytes 0xAC to 0xAF = 0C 06 0C 00
- R10: A registration request raises `reg_accept` in the same cycle when its number is below NUM_DEV and not yet present, and marks the number present from the next cycle on. Otherwise it raises `reg_reject` and leaves the table unchanged. Reset clears the table.
- R11: `acc_err` is high for exactly the cycle after each access that was dropped under R2, R5 or R8, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_wr | input | 1 | Load strobe for the configuration address |
| addr_wdata | input | 32 | New configuration address value |
| addr_q | output | 32 | Current configuration address |
| acc_valid | input | 1 | Configuration data access this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_size | input | 3 | Access size in bytes (1, 2 or 4 valid) |
| acc_wdata | input | 32 | Write data, right-aligned |
| acc_rdata | output | 32 | Read data, combinational, right-aligned |
| acc_err | output | 1 | One-cycle flag after a dropped access |
| reg_valid | input | 1 | Registration request |
| reg_devnum | input | 5 | Device number to register |
| reg_accept | output | 1 | Registration accepted (same cycle) |
| reg_reject | output | 1 | Registration rejected (same cycle) |
| dev_off | output | 8 | Aligned register offset to ports |
| dev_wdata | output | 32 | Write data to ports |
| dev_size | output | 3 | Access size to ports |
| dev_sel | output | NUM_DEV | One-hot port select |
| dev_rd | output | NUM_DEV | Per-port read strobe |
| dev_wr | output | NUM_DEV | Per-port write strobe |
| dev_rdata | input | NUM_DEV*32 | Read data from each port, port k at bits k*32 upward |

## Verification
The bench builds the block with NUM_DEV set to 24, not the default 32. With that setting the 5-bit device field can name numbers the block has no port for. Device 31 is therefore both a refused registration and a missed access, while device 23 checks the top port select. Each port returns data that depends on its number and on the offset it is shown, so a wrong select or a wrong offset produces a visible mismatch. Device number 0 is registered as well, which shows that function 0 still reaches the local header while function 1 reaches port 0.

// File: rtl/pcicfg_pkg.sv
package pcicfg_pkg;

    localparam int DATA_W    = 32;
    localparam int HDR_BYTES = 256;
    localparam int OFF_W     = $clog2(HDR_BYTES);
    localparam int DEVNUM_W  = 5;
    localparam int FN_W      = 3;
    localparam int BUS_W     = 8;
    localparam int DEV_SPAN  = 1 << DEVNUM_W;

    localparam logic [2:0] SZ_BYTE = 3'd1;
    localparam logic [2:0] SZ_HALF = 3'd2;
    localparam logic [2:0] SZ_WORD = 3'd4;

    // Decoded view of bits 31:8 of the configuration address register.
    typedef struct packed {
        logic [OFF_W-1:0]    off;
        logic [DEVNUM_W-1:0] dev;
        logic [FN_W-1:0]     fn;
        logic [BUS_W-1:0]    bus;
    } cfg_fields_t;

    typedef enum logic [1:0] {
        ROUTE_DROP  = 2'd0,
        ROUTE_LOCAL = 2'd1,
        ROUTE_PORT  = 2'd2
    } route_e;

    function automatic logic size_ok(input logic [2:0] sz);
        return (sz == SZ_BYTE) || (sz == SZ_HALF) || (sz == SZ_WORD);
    endfunction

    function automatic logic [7:0] hdr_reset_byte(input int unsigned idx);
        logic [7:0] b;
        case (idx)
            32'h06:  b = 8'h80;
            32'h08:  b = 8'h40;
            32'h0B:  b = 8'h06;
            32'h73:  b = 8'hCD;
            32'hA8:  b = 8'h10;
            32'hAB:  b = 8'hFF;
            32'hAC:  b = 8'h0C;
            32'hAD:  b = 8'h06;
            32'hAE:  b = 8'h0C;
            default: b = 8'h00;
        endcase
        return b;
    endfunction

    function automatic logic [31:0] cfg_addr_pack(input logic [7:0] off,
                                                  input logic [4:0] dev,
                                                  input logic [2:0] fn,
                                                  input logic [7:0] bus);
        return {off, dev, fn, bus, 8'h00};
    endfunction

endpackage

// File: rtl/pcicfg_addr_reg.sv
module pcicfg_addr_reg
    import pcicfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] raw,
    output cfg_fields_t       fields
);

    always_ff @(posedge clk) begin
        if (rst) begin
            raw <= '0;
        end else if (load) begin
            raw <= wdata;
        end
    end

    // Offset is always word aligned: the two low offset bits are ignored.
    always_comb begin
        fields         = cfg_fields_t'(raw[DATA_W-1:8]);
        fields.off[1:0] = 2'b00;
    end

endmodule

// File: rtl/pcicfg_hdr_file.sv
module pcicfg_hdr_file
    import pcicfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  off,
    input  logic [2:0]        size,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int WIDX_W = OFF_W - 2;

    logic [7:0]        hdr [HDR_BYTES];
    logic [WIDX_W-1:0] widx;
    logic [7:0]        lane [4];

    assign widx = off[OFF_W-1:2];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < HDR_BYTES; i++) begin
                hdr[i] <= hdr_reset_byte(i);
            end
        end else if (wr_en) begin
            case (size)
                SZ_BYTE: begin
                    hdr[{widx, 2'd0}] <= wdata[7:0];
                end
                SZ_HALF: begin
                    hdr[{widx, 2'd0}] <= wdata[15:8];
                    hdr[{widx, 2'd1}] <= wdata[7:0];
                end
                SZ_WORD: begin
                    hdr[{widx, 2'd0}] <= wdata[31:24];
                    hdr[{widx, 2'd1}] <= wdata[23:16];
                    hdr[{widx, 2'd2}] <= wdata[15:8];
                    hdr[{widx, 2'd3}] <= wdata[7:0];
                end
                default: ;
            endcase
        end
    end

    for (genvar k = 0; k < 4; k++) begin : g_lane
        assign lane[k] = hdr[{widx, 2'(k)}];
    end

    always_comb begin
        case (size)
            SZ_BYTE: rdata = {24'h0, lane[0]};
            SZ_HALF: rdata = {16'h0, lane[0], lane[1]};
            SZ_WORD: rdata = {lane[0], lane[1], lane[2], lane[3]};
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/pcicfg_dev_registry.sv
module pcicfg_dev_registry
    import pcicfg_pkg::*;
#(
    parameter int NUM_DEV = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_valid,
    input  logic [DEVNUM_W-1:0] reg_num,
    output logic                reg_accept,
    output logic                reg_reject,
    input  logic [DEVNUM_W-1:0] q_num,
    output logic                q_present
);

    logic [NUM_DEV-1:0]  present;
    logic [DEV_SPAN-1:0] pad;
    logic                in_range;

    assign pad       = DEV_SPAN'(present);
    assign in_range  = (32'(reg_num) < NUM_DEV);
    assign q_present = pad[q_num];

    assign reg_accept = reg_valid && in_range && !pad[reg_num];
    assign reg_reject = reg_valid && !reg_accept;

    always_ff @(posedge clk) begin
        if (rst) begin
            present <= '0;
        end else if (reg_accept) begin
            present <= present | NUM_DEV'(DEV_SPAN'(1) << reg_num);
        end
    end

endmodule

// File: rtl/pcicfg_port_fanout.sv
module pcicfg_port_fanout
    import pcicfg_pkg::*;
#(
    parameter int NUM_DEV = 32
) (
    input  logic                      fwd,
    input  logic                      write,
    input  logic [DEVNUM_W-1:0]       dev_num,
    input  logic [NUM_DEV*DATA_W-1:0] port_rdata,
    output logic [NUM_DEV-1:0]        sel,
    output logic [NUM_DEV-1:0]        rd,
    output logic [NUM_DEV-1:0]        wr,
    output logic [DATA_W-1:0]         rdata
);

    for (genvar k = 0; k < NUM_DEV; k++) begin : g_port
        assign sel[k] = fwd && (dev_num == DEVNUM_W'(k));
        assign rd[k]  = sel[k] && !write;
        assign wr[k]  = sel[k] && write;
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < NUM_DEV; k++) begin
            if (sel[k]) begin
                rdata = rdata | port_rdata[k*DATA_W +: DATA_W];
            end
        end
    end

endmodule

// File: rtl/pcicfg_router.sv
module pcicfg_router
    import pcicfg_pkg::*;
#(
    parameter int NUM_DEV = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      addr_wr,
    input  logic [31:0]               addr_wdata,
    output logic [31:0]               addr_q,
    input  logic                      acc_valid,
    input  logic                      acc_write,
    input  logic [2:0]                acc_size,
    input  logic [31:0]               acc_wdata,
    output logic [31:0]               acc_rdata,
    output logic                      acc_err,
    input  logic                      reg_valid,
    input  logic [4:0]                reg_devnum,
    output logic                      reg_accept,
    output logic                      reg_reject,
    output logic [7:0]                dev_off,
    output logic [31:0]               dev_wdata,
    output logic [2:0]                dev_size,
    output logic [NUM_DEV-1:0]        dev_sel,
    output logic [NUM_DEV-1:0]        dev_rd,
    output logic [NUM_DEV-1:0]        dev_wr,
    input  logic [NUM_DEV*32-1:0]     dev_rdata
);

    cfg_fields_t       fld;
    route_e            route;
    logic              present;
    logic              bus_nz;
    logic              is_local;
    logic [DATA_W-1:0] hdr_rdata;
    logic [DATA_W-1:0] port_mux;

    pcicfg_addr_reg u_addr (
        .clk    (clk),
        .rst    (rst),
        .load   (addr_wr),
        .wdata  (addr_wdata),
        .raw    (addr_q),
        .fields (fld)
    );

    pcicfg_dev_registry #(.NUM_DEV(NUM_DEV)) u_reg (
        .clk        (clk),
        .rst        (rst),
        .reg_valid  (reg_valid),
        .reg_num    (reg_devnum),
        .reg_accept (reg_accept),
        .reg_reject (reg_reject),
        .q_num      (fld.dev),
        .q_present  (present)
    );

    assign bus_nz   = (fld.bus != '0);
    assign is_local = (fld.dev == '0) && (fld.fn == '0);

    // Priority: bus check, then size check, then local header, then port table.
    always_comb begin
        route = ROUTE_DROP;
        if (acc_valid && !bus_nz && size_ok(acc_size)) begin
            if (is_local) begin
                route = ROUTE_LOCAL;
            end else if (present) begin
                route = ROUTE_PORT;
            end
        end
    end

    pcicfg_hdr_file u_hdr (
        .clk   (clk),
        .rst   (rst),
        .wr_en (route == ROUTE_LOCAL && acc_write),
        .off   (fld.off),
        .size  (acc_size),
        .wdata (acc_wdata),
        .rdata (hdr_rdata)
    );

    pcicfg_port_fanout #(.NUM_DEV(NUM_DEV)) u_fan (
        .fwd        (route == ROUTE_PORT),
        .write      (acc_write),
        .dev_num    (fld.dev),
        .port_rdata (dev_rdata),
        .sel        (dev_sel),
        .rd         (dev_rd),
        .wr         (dev_wr),
        .rdata      (port_mux)
    );

    assign dev_off   = fld.off;
    assign dev_wdata = acc_wdata;
    assign dev_size  = acc_size;

    always_comb begin
        acc_rdata = '0;
        if (!acc_write) begin
            case (route)
                ROUTE_LOCAL: acc_rdata = hdr_rdata;
                ROUTE_PORT:  acc_rdata = port_mux;
                default:     acc_rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_err <= 1'b0;
        end else begin
            acc_err <= acc_valid && (route == ROUTE_DROP);
        end
    end

endmodule

// File: rtl/pcicfg_router_chk.sv
module pcicfg_router_chk #(
    parameter int NUM_DEV = 32
) (
    input logic               clk,
    input logic               rst,
    input logic [31:0]        addr_q,
    input logic               acc_valid,
    input logic               acc_write,
    input logic [2:0]         acc_size,
    input logic [31:0]        acc_rdata,
    input logic               acc_err,
    input logic               reg_valid,
    input logic [4:0]         reg_devnum,
    input logic               reg_accept,
    input logic               reg_reject,
    input logic [NUM_DEV-1:0] dev_sel,
    input logic [NUM_DEV-1:0] dev_rd,
    input logic [NUM_DEV-1:0] dev_wr
);

    // R4
    sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dev_sel));

    // R4
    strobe_match_chk: assert property (@(posedge clk) disable iff (rst)
        ((dev_rd | dev_wr) == dev_sel) && ((dev_wr != '0) -> acc_write));

    // R2
    bus_block_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && addr_q[15:8] != 8'h00) |-> (dev_sel == '0 && acc_rdata == '0));

    // R8
    size_block_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !(acc_size inside {3'd1, 3'd2, 3'd4})) |-> (dev_sel == '0 && acc_rdata == '0));

    // R3
    local_no_port_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && addr_q[23:16] == 8'h00) |-> (dev_sel == '0));

    // R11
    err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        acc_err |-> $past(acc_valid));

    // R11
    err_bus_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && addr_q[15:8] != 8'h00) |=> acc_err);

    // R10
    reg_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(reg_accept && reg_reject) && ((reg_accept || reg_reject) -> reg_valid));

    // R10
    reg_twice_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_valid && $past(reg_accept) && !$past(rst) && reg_devnum == $past(reg_devnum))
            |-> reg_reject);

endmodule

bind pcicfg_router pcicfg_router_chk #(.NUM_DEV(NUM_DEV)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .addr_q     (addr_q),
    .acc_valid  (acc_valid),
    .acc_write  (acc_write),
    .acc_size   (acc_size),
    .acc_rdata  (acc_rdata),
    .acc_err    (acc_err),
    .reg_valid  (reg_valid),
    .reg_devnum (reg_devnum),
    .reg_accept (reg_accept),
    .reg_reject (reg_reject),
    .dev_sel    (dev_sel),
    .dev_rd     (dev_rd),
    .dev_wr     (dev_wr)
);

// File: tb/pcicfg_router_tb_top.sv
module pcicfg_router_tb_top;
    import pcicfg_pkg::*;

    localparam int NDEV = 24;

    localparam logic [1:0] OP_ADDR = 2'd0;
    localparam logic [1:0] OP_RD   = 2'd1;
    localparam logic [1:0] OP_WR   = 2'd2;
    localparam logic [1:0] OP_REG  = 2'd3;

    typedef struct packed {
        logic [1:0]      op;
        logic [31:0]     arg;
        logic [2:0]      size;
        logic [31:0]     exp;
        logic            exp_err;
        logic [NDEV-1:0] sel;
        logic [3:0]      req;
    } vec_t;

    function automatic logic [31:0] port_model(input int k, input logic [7:0] off);
        return {8'(k), 8'hA5, off, 8'h3C};
    endfunction

    localparam int NVEC = 43;
    localparam vec_t VECS [NVEC] = '{
        '{OP_ADDR, cfg_addr_pack(8'h08, 5'd0, 3'd0, 8'd0), 3'd0, 32'h0,        1'b0, 24'h0, 4'd1},
        '{OP_RD,   32'h0, 3'd4, 32'h40000006, 1'b0, 24'h0, 4'd9},   // R9 class/revision
        '{OP_ADDR, cfg_addr_pack(8'h04, 5'd0, 3'd0, 8'd0), 3'd0, 32'h0,        1'b0, 24'h0, 4'd1},
        '{OP_RD,   32'h0, 3'd4, 32'h00008000, 1'b0, 24'h0, 4'd9},   // R9 status
        '{OP_ADDR, cfg_addr_pack(8'h70, 5'd0, 3'd0, 8'd0), 3'd0, 32'h0,        1'b0, 24'h0, 4'd1},
        '{OP_RD,   32'h0, 3'd4, 32'h000000CD, 1'b0, 24'h0, 4'd9},   // R9 byte 0x73
        '{OP_ADDR, cfg_addr_pack(8'hAB, 5'd0, 3'd0, 8'd0), 3'd0, 32'h0,        1'b0, 24'h0, 4'd1},
        '{OP_RD,   32'h0, 3'd4, 32'h100000FF, 1'b0, 24'h0, 4'd1},   // R1 low offset bits ignored
        '{OP_ADDR, cfg_addr_pack(8'hAC, 5'd0, 3'd0, 8'd0), 3'd0, 32'h0,        1'b0, 24'h0, 4'd1},
        '{OP_RD,   32'h0, 3'd2, 32'h00000C06, 1'b0, 24'h0, 4'd6},   // R6 half
        '{OP_RD,   32'h0, 3'd1, 32'h0000000C, 1'b0, 24'h0, 4'd6},   // R6 byte
        '{OP_WR,   32'h11223344, 3'd4, 32'h0, 1'b0, 24'h0, 4'd7},   // R7 word
        '{OP_RD,   32'h0, 3'd4, 32'h11223344, 1'b0, 24'h0, 4'd7},
        '{OP_WR,   32'h0000BEEF, 3'd2, 32'h0, 1'b0, 24'h0, 4'd7},   // R7 half
        '{OP_RD,   32'h0, 3'd4, 32'hBEEF3344, 1'b0, 24'h0, 4'd7},
        '{OP_WR,   32'h0000005A, 3'd1, 32'h0, 1'b0, 24'h0, 4'd7},   // R7 byte
        '{OP_RD,   32'h0, 3'd4, 32'h5AEF3344, 1'b0, 24'h0, 4'd7},
        '{OP_WR,   32'hFFFFFFFF, 3'd3, 32'h0, 1'b1, 24'h0, 4'd8},   // R8 bad size write, R11
        '{OP_RD,   32'h0, 3'd3, 32'h0,        1'b1, 24'h0, 4'd8},   // R8 bad size read
        '{OP_RD,   32'h0, 3'd4, 32'h5AEF3344, 1'b0, 24'h0, 4'd8},   // R8 nothing written
        '{OP_ADDR, cfg_addr_pack(8'hAC, 5'd0, 3'd0, 8'd1), 3'd0, 32'h0,        1'b0, 24'h0, 4'd2},
        '{OP_RD,   32'h0, 3'd4, 32'h0,        1'b1, 24'h0, 4'd2},   // R2 bus 1 read
        '{OP_WR,   32'h0, 3'd4, 32'h0,        1'b1, 24'h0, 4'd2},   // R2 bus 1 write
        '{OP_ADDR, cfg_addr_pack(8'hAC, 5'd0, 3'd0, 8'd0), 3'd0, 32'h0,        1'b0, 24'h0, 4'd2},
        '{OP_RD,   32'h0, 3'd4, 32'h5AEF3344, 1'b0, 24'h0, 4'd2},   // R2 write had no effect
        '{OP_ADDR, cfg_addr_pack(8'h10, 5'd5, 3'd0, 8'd0), 3'd0, 32'h0,        1'b0, 24'h0, 4'd1},
        '{OP_RD,   32'h0, 3'd4, 32'h0,        1'b1, 24'h0, 4'd5},   // R5 unregistered
        '{OP_REG,  32'd5, 3'd0, 32'h1,        1'b0, 24'h0, 4'd10},  // R10 accept
        '{OP_REG,  32'd5, 3'd0, 32'h0,        1'b0, 24'h0, 4'd10},  // R10 duplicate
        '{OP_RD,   32'h0, 3'd4, port_model(5, 8'h10), 1'b0, 24'h000020, 4'd4}, // R4
        '{OP_WR,   32'hCAFEF00D, 3'd4, 32'h0, 1'b0, 24'h000020, 4'd4},          // R4
        '{OP_RD,   32'h0, 3'd2, port_model(5, 8'h10), 1'b0, 24'h000020, 4'd4},
        '{OP_REG,  32'd31, 3'd0, 32'h0,       1'b0, 24'h0, 4'd10},  // R10 out of range
        '{OP_ADDR, cfg_addr_pack(8'h40, 5'd31, 3'd0, 8'd0), 3'd0, 32'h0,       1'b0, 24'h0, 4'd1},
        '{OP_RD,   32'h0, 3'd4, 32'h0,        1'b1, 24'h0, 4'd5},   // R5 no such port
        '{OP_REG,  32'd23, 3'd0, 32'h1,       1'b0, 24'h0, 4'd10},
        '{OP_ADDR, cfg_addr_pack(8'hFC, 5'd23, 3'd2, 8'd0), 3'd0, 32'h0,       1'b0, 24'h0, 4'd1},
        '{OP_RD,   32'h0, 3'd4, port_model(23, 8'hFC), 1'b0, 24'h800000, 4'd4}, // R4 top port
        '{OP_REG,  32'd0, 3'd0, 32'h1,        1'b0, 24'h0, 4'd10},
        '{OP_ADDR, cfg_addr_pack(8'h20, 5'd0, 3'd1, 8'd0), 3'd0, 32'h0,        1'b0, 24'h0, 4'd3},
        '{OP_RD,   32'h0, 3'd1, port_model(0, 8'h20), 1'b0, 24'h000001, 4'd3},  // R3 fn1 goes out
        '{OP_ADDR, cfg_addr_pack(8'h20, 5'd0, 3'd0, 8'd0), 3'd0, 32'h0,        1'b0, 24'h0, 4'd3},
        '{OP_RD,   32'h0, 3'd4, 32'h0,        1'b0, 24'h0, 4'd3}    // R3 fn0 stays local
    };

    logic                 clk = 1'b0;
    logic                 rst;
    logic                 addr_wr;
    logic [31:0]          addr_wdata;
    logic [31:0]          addr_q;
    logic                 acc_valid;
    logic                 acc_write;
    logic [2:0]           acc_size;
    logic [31:0]          acc_wdata;
    logic [31:0]          acc_rdata;
    logic                 acc_err;
    logic                 reg_valid;
    logic [4:0]           reg_devnum;
    logic                 reg_accept;
    logic                 reg_reject;
    logic [7:0]           dev_off;
    logic [31:0]          dev_wdata;
    logic [2:0]           dev_size;
    logic [NDEV-1:0]      dev_sel;
    logic [NDEV-1:0]      dev_rd;
    logic [NDEV-1:0]      dev_wr;
    logic [NDEV*32-1:0]   dev_rdata;

    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;
    logic [31:0] cur_addr;
    vec_t t;

    always #2 clk = ~clk;

    for (genvar k = 0; k < NDEV; k++) begin : g_model
        assign dev_rdata[k*32 +: 32] = port_model(k, dev_off);
    end

    pcicfg_router #(.NUM_DEV(NDEV)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .addr_wr    (addr_wr),
        .addr_wdata (addr_wdata),
        .addr_q     (addr_q),
        .acc_valid  (acc_valid),
        .acc_write  (acc_write),
        .acc_size   (acc_size),
        .acc_wdata  (acc_wdata),
        .acc_rdata  (acc_rdata),
        .acc_err    (acc_err),
        .reg_valid  (reg_valid),
        .reg_devnum (reg_devnum),
        .reg_accept (reg_accept),
        .reg_reject (reg_reject),
        .dev_off    (dev_off),
        .dev_wdata  (dev_wdata),
        .dev_size   (dev_size),
        .dev_sel    (dev_sel),
        .dev_rd     (dev_rd),
        .dev_wr     (dev_wr),
        .dev_rdata  (dev_rdata)
    );

    task automatic chk(input string what, input int req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        addr_wr   = 1'b0;
        acc_valid = 1'b0;
        acc_write = 1'b0;
        acc_size  = 3'd0;
        acc_wdata = '0;
        reg_valid = 1'b0;
        reg_devnum = '0;
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic run_vec(input vec_t v);
        case (v.op)
            OP_ADDR: begin addr_wr = 1'b1; addr_wdata = v.arg; cur_addr = v.arg; end
            OP_RD:   begin acc_valid = 1'b1; acc_write = 1'b0; acc_size = v.size; end
            OP_WR:   begin acc_valid = 1'b1; acc_write = 1'b1; acc_size = v.size; acc_wdata = v.arg; end
            default: begin reg_valid = 1'b1; reg_devnum = v.arg[4:0]; end
        endcase
        #1;
        if (v.op == OP_RD) begin
            chk("read data", v.req, acc_rdata, v.exp);
            chk("read strobes", v.req, 32'(dev_rd), 32'(v.sel));
            chk("selects", v.req, 32'(dev_sel), 32'(v.sel));
        end
        if (v.op == OP_WR) begin
            chk("write strobes", v.req, 32'(dev_wr), 32'(v.sel));
            if (v.sel != '0) begin
                chk("port wdata", v.req, dev_wdata, v.arg);
                chk("port offset", v.req, 32'(dev_off), 32'({cur_addr[31:26], 2'b00}));
                chk("port size", v.req, 32'(dev_size), 32'(v.size));
            end
        end
        if (v.op == OP_REG) begin
            chk("reg accept", v.req, 32'(reg_accept), 32'(v.exp[0]));
            chk("reg reject", v.req, 32'(reg_reject), 32'(!v.exp[0]));
        end
        @(negedge clk);
        idle_inputs();
        // R11: flag registered one cycle after the access
        chk("error flag", 11, 32'(acc_err), 32'(v.exp_err));
    endtask

    initial begin
        rst = 1'b1;
        idle_inputs();
        addr_wdata = '0;
        cur_addr   = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 R11 reset state
        chk("addr reset", 1, addr_q, 32'h0);
        chk("err reset", 11, 32'(acc_err), 32'h0);
        chk("sel idle", 4, 32'(dev_sel), 32'h0);

        for (int v = 0; v < NVEC; v++) begin
            t = VECS[v];
            run_vec(t);
        end

        // R1 load visible on readback
        chk("addr readback", 1, addr_q, cfg_addr_pack(8'h20, 5'd0, 3'd0, 8'd0));

        // R9 R10: reset restores header and clears the table
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("addr after reset", 1, addr_q, 32'h0);
        @(negedge clk);
        t = '{OP_ADDR, cfg_addr_pack(8'hAC, 5'd0, 3'd0, 8'd0), 3'd0, 32'h0, 1'b0, 24'h0, 4'd9};
        run_vec(t);
        t = '{OP_RD, 32'h0, 3'd4, 32'h0C060C00, 1'b0, 24'h0, 4'd9};
        run_vec(t);
        t = '{OP_REG, 32'd5, 3'd0, 32'h1, 1'b0, 24'h0, 4'd10};
        run_vec(t);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule